// File: doc/BRIEF.md
# Five-Stage In-Order Load/Store Pipeline

This block is a compact in-order integer datapath that executes a 32-bit instruction subset: four register-to-register operations (add, subtract, bitwise and, bitwise or), add-with-immediate, word load and word store. An instruction passes through five stages in turn: fetch, decode with register read, execute, memory access and write-back. A pipeline register separates each pair of stages. When the pipeline is full, five instructions are in flight.

The instruction store and the data store are two separate word arrays inside the block, so fetch and data access never compete. The environment fills them through a load port, normally while reset is held. A read port for the data array shows stored results. The write-back stage is also visible at the ports.

There is no hazard detection, no forwarding and no control transfer. Software must place independent instructions or no-ops between a producer and its consumer.

Top module: `pl_core`

## Requirements
- R1: While reset is low, and for the first three rising edges after it is released, `wb_en` is 0. Reset sets the fetch address to 0 and clears every pipeline register to a no-op.
- R2: Edges are counted from 1 at the first rising edge with reset high. The instruction in word k of the instruction array is shown on `wb_en`/`wb_reg`/`wb_data` after edge k+4.
- R3: The encoding is as follows. The opcode is in bits [31:26]. Source register rs is in [25:21], rt in [20:16], rd in [15:11], and the immediate in [15:0]. Opcode 0 is a no-op, as is any opcode not listed here. Opcode 1 is register-register, with the function in [5:0]: 0 add, 1 sub, 2 and, 3 or. Any other function value is a no-op. Opcode 2 is add-immediate, 3 is word load and 4 is word store.
- R4: Add and subtract results are taken modulo 2^32. The and and or operations work bit by bit.
- R5: The immediate is sign-extended. Add-immediate, and the address of a load or a store, use rs plus the extended immediate.
- R6: Register-register instructions write rd. Add-immediate and load write rt. Stores and no-ops raise no write (`wb_en` 0).
- R7: Register 0 always reads as 0. An instruction whose destination is 0 leaves it at 0, and `wb_en` stays 0 for it.
- R8: A register written back in the same cycle that decode reads it returns the new value. A consumer placed three slots after its producer (two instructions between them) therefore sees the result.
- R9: A load returns the data word at byte address bits [MEM_AW+1:2]. A store writes the rt value to that word in its memory stage. A later load returns the stored value.
- R10: The fetch address grows by 4 on every edge after reset. The address indexes the instruction array with bits [MEM_AW+1:2].
- R11: The load port writes `ld_data` into the word `ld_addr` of the instruction array or the data array, selected by the two enables. `dbg_data` shows the data-array word at `dbg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_imem_we | input | 1 | Write ld_data into the instruction array |
| ld_dmem_we | input | 1 | Write ld_data into the data array |
| ld_addr | input | MEM_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| dbg_addr | input | MEM_AW | Word index of the data-array read port |
| dbg_data | output | 32 | Data-array word at dbg_addr |
| wb_en | output | 1 | Write-back stage writes a register this cycle |
| wb_reg | output | 5 | Destination register in write-back |
| wb_data | output | 32 | Value being written back |

## Verification
The two functions that can fall in the same cycle are the write-back of a register and the decode-stage read of that same register. The test program provokes this by loading an operand and issuing an add that uses it exactly three slots later. The add's write-back value must then equal the sum of the new operands and not the old register contents. A second overlap, a store in its memory stage while fetch reads the instruction array, is judged by reading back the stored words through the debug port and by a later load that returns them. The program runs once for each of many corner and generated operand pairs, and every write-back cycle is compared with an arithmetic model.

// File: rtl/pl_pkg.sv
package pl_pkg;

    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);

    localparam logic [5:0] OPC_NOP   = 6'd0;
    localparam logic [5:0] OPC_RR    = 6'd1;
    localparam logic [5:0] OPC_ADDI  = 6'd2;
    localparam logic [5:0] OPC_LOAD  = 6'd3;
    localparam logic [5:0] OPC_STORE = 6'd4;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        alu_op_e           op;
        logic              use_imm;
        logic              we;
        logic              is_load;
        logic              is_store;
        logic [RIDX_W-1:0] rd;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc4;
    } ifid_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] rs_val;
        logic [XLEN-1:0] rt_val;
        logic [XLEN-1:0] imm_ext;
        ctrl_t           ctrl;
    } idex_t;

    typedef struct packed {
        logic [XLEN-1:0]   alu;
        logic [XLEN-1:0]   rt_val;
        logic [XLEN-1:0]   pc4;
        logic [RIDX_W-1:0] rd;
        logic              we;
        logic              is_load;
        logic              is_store;
    } exmem_t;

    typedef struct packed {
        logic [XLEN-1:0]   alu;
        logic [XLEN-1:0]   rdata;
        logic [RIDX_W-1:0] rd;
        logic              we;
        logic              is_load;
    } memwb_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        ifid_t           ifid;
        idex_t           idex;
        exmem_t          exmem;
        memwb_t          memwb;
    } pipe_t;

endpackage

// File: rtl/pl_decode.sv
module pl_decode
    import pl_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;

    always_comb begin
        opc  = instr[31:26];
        fn   = instr[5:0];
        ctrl = '0;
        case (opc)
            OPC_RR: begin
                if (fn < 6'd4) begin
                    ctrl.op = alu_op_e'(fn[1:0]);
                    ctrl.we = 1'b1;
                    ctrl.rd = instr[15:11];
                end
            end
            OPC_ADDI: begin
                ctrl.use_imm = 1'b1;
                ctrl.we      = 1'b1;
                ctrl.rd      = instr[20:16];
            end
            OPC_LOAD: begin
                ctrl.use_imm = 1'b1;
                ctrl.we      = 1'b1;
                ctrl.is_load = 1'b1;
                ctrl.rd      = instr[20:16];
            end
            OPC_STORE: begin
                ctrl.use_imm  = 1'b1;
                ctrl.is_store = 1'b1;
            end
            default: ctrl = '0;
        endcase
        if (ctrl.rd == '0) begin
            ctrl.we = 1'b0;
        end
    end
endmodule

// File: rtl/pl_alu.sv
module pl_alu
    import pl_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pl_regfile.sv
module pl_regfile
    import pl_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b
);
    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    function automatic logic [XLEN-1:0] rd_port(input logic [RIDX_W-1:0] ra,
                                                 input logic [XLEN-1:0] cur);
        if (ra == '0)
            return '0;
        else if (we && (waddr == ra))
            return wdata;
        else
            return cur;
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rdata_a = rd_port(raddr_a, regs_q[raddr_a]);
    assign rdata_b = rd_port(raddr_b, regs_q[raddr_b]);
endmodule

// File: rtl/pl_core.sv
module pl_core
    import pl_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_imem_we,
    input  logic              ld_dmem_we,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    input  logic [MEM_AW-1:0] dbg_addr,
    output logic [31:0]       dbg_data,
    output logic              wb_en,
    output logic [4:0]        wb_reg,
    output logic [31:0]       wb_data
);
    localparam int MEM_WORDS = 1 << MEM_AW;

    pipe_t pipe_q, pipe_d;

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    ctrl_t           dec_ctrl;
    logic [XLEN-1:0] rf_a, rf_b;
    logic [XLEN-1:0] alu_b, alu_y;
    logic [XLEN-1:0] wb_val;
    logic [MEM_AW-1:0] dm_idx;

    pl_decode u_dec (
        .instr (pipe_q.ifid.instr),
        .ctrl  (dec_ctrl)
    );

    pl_regfile u_rf (
        .clk     (clk),
        .we      (pipe_q.memwb.we),
        .waddr   (pipe_q.memwb.rd),
        .wdata   (wb_val),
        .raddr_a (pipe_q.ifid.instr[25:21]),
        .raddr_b (pipe_q.ifid.instr[20:16]),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    assign alu_b = pipe_q.idex.ctrl.use_imm ? pipe_q.idex.imm_ext : pipe_q.idex.rt_val;

    pl_alu u_alu (
        .op (pipe_q.idex.ctrl.op),
        .a  (pipe_q.idex.rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign dm_idx = pipe_q.exmem.alu[2 +: MEM_AW];
    assign wb_val = pipe_q.memwb.is_load ? pipe_q.memwb.rdata : pipe_q.memwb.alu;

    always_comb begin
        pipe_d = pipe_q;

        // fetch
        pipe_d.pc         = pipe_q.pc + 32'd4;
        pipe_d.ifid.instr = imem[pipe_q.pc[2 +: MEM_AW]];
        pipe_d.ifid.pc4   = pipe_q.pc + 32'd4;

        // decode / register read
        pipe_d.idex.instr   = pipe_q.ifid.instr;
        pipe_d.idex.pc4     = pipe_q.ifid.pc4;
        pipe_d.idex.rs_val  = rf_a;
        pipe_d.idex.rt_val  = rf_b;
        pipe_d.idex.imm_ext = {{16{pipe_q.ifid.instr[15]}}, pipe_q.ifid.instr[15:0]};
        pipe_d.idex.ctrl    = dec_ctrl;

        // execute
        pipe_d.exmem.alu      = alu_y;
        pipe_d.exmem.rt_val   = pipe_q.idex.rt_val;
        pipe_d.exmem.pc4      = pipe_q.idex.pc4;
        pipe_d.exmem.rd       = pipe_q.idex.ctrl.rd;
        pipe_d.exmem.we       = pipe_q.idex.ctrl.we;
        pipe_d.exmem.is_load  = pipe_q.idex.ctrl.is_load;
        pipe_d.exmem.is_store = pipe_q.idex.ctrl.is_store;

        // memory access
        pipe_d.memwb.alu     = pipe_q.exmem.alu;
        pipe_d.memwb.rdata   = dmem[dm_idx];
        pipe_d.memwb.rd      = pipe_q.exmem.rd;
        pipe_d.memwb.we      = pipe_q.exmem.we;
        pipe_d.memwb.is_load = pipe_q.exmem.is_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    always_ff @(posedge clk) begin
        if (ld_imem_we) imem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_dmem_we)                                dmem[ld_addr] <= ld_data;
        else if (rst_n && pipe_q.exmem.is_store)       dmem[dm_idx]  <= pipe_q.exmem.rt_val;
    end

    assign dbg_data = dmem[dbg_addr];
    assign wb_en    = pipe_q.memwb.we;
    assign wb_reg   = pipe_q.memwb.rd;
    assign wb_data  = wb_val;
endmodule

// File: rtl/pl_core_chk.sv
module pl_core_chk
    import pl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input pipe_t      pipe,
    input logic       wb_en,
    input logic [4:0] wb_reg
);
    assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pipe.pc == $past(pipe.pc) + 32'd4);

    assert_ifid_link_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pipe.ifid.pc4 == $past(pipe.pc) + 32'd4);

    assert_dest_travel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pipe.memwb.rd == $past(pipe.exmem.rd)) &&
                         (pipe.exmem.rd == $past(pipe.idex.ctrl.rd)) &&
                         (pipe.exmem.pc4 == $past(pipe.idex.pc4)) &&
                         (pipe.idex.instr == $past(pipe.ifid.instr)));

    assert_store_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pipe.exmem.is_store |-> !pipe.exmem.we);

    assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe.idex.instr[25:21] == 5'd0) |-> pipe.idex.rs_val == 32'd0);

    assert_no_r0_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_reg != 5'd0);
endmodule

bind pl_core pl_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pipe   (pipe_q),
    .wb_en  (wb_en),
    .wb_reg (wb_reg)
);

// File: tb/pl_core_bench.sv
module pl_core_bench;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
    logic [AW-1:0] ld_addr = '0, dbg_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   dbg_data, wb_data;
    logic          wb_en;
    logic [4:0]    wb_reg;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    pl_core #(.MEM_AW(AW)) u_pl_core (
        .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] enc_rr(int fn, int rd, int rs, int rt);
        return {6'd1, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int opc, int rt, int rs, int imm);
        return {6'(opc), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] prog(int k);
        case (k)
            0:  return enc_i(3, 1, 0, 0);      // load r1 <- [0]
            1:  return enc_i(3, 2, 0, 4);      // load r2 <- [4]
            2:  return enc_i(2, 8, 0, 64);     // r8 = 64
            3:  return 32'd0;
            4:  return enc_rr(0, 3, 1, 2);     // add (three slots after r2 load)
            5:  return enc_rr(1, 4, 1, 2);
            6:  return enc_rr(2, 5, 1, 2);
            7:  return enc_rr(3, 6, 1, 2);
            8:  return enc_i(2, 7, 1, -3);
            9:  return enc_i(2, 0, 0, 5);      // write to r0
            10: return enc_i(4, 3, 8, 0);
            11: return enc_i(4, 4, 8, 4);
            12: return enc_i(4, 5, 8, 8);
            13: return enc_i(4, 6, 8, 12);
            14: return enc_i(4, 7, 8, 16);
            15: return enc_i(4, 0, 8, -4);     // store r0 to word 15
            16: return enc_i(3, 9, 8, 0);      // load back word 16
            default: return 32'd0;
        endcase
    endfunction

    task automatic exp_wb(int k, logic [31:0] a, logic [31:0] b,
                          output logic en, output int rg, output logic [31:0] d);
        en = 1'b1; rg = 0; d = '0;
        case (k)
            0:  begin rg = 1; d = a; end
            1:  begin rg = 2; d = b; end
            2:  begin rg = 8; d = 32'd64; end
            4:  begin rg = 3; d = a + b; end
            5:  begin rg = 4; d = a - b; end
            6:  begin rg = 5; d = a & b; end
            7:  begin rg = 6; d = a | b; end
            8:  begin rg = 7; d = a - 32'd3; end
            16: begin rg = 9; d = a + b; end
            default: en = 1'b0;
        endcase
    endtask

    task automatic ld_word(input logic imem_sel, input int adr, input logic [31:0] d);
        @(negedge clk);
        ld_imem_we = imem_sel; ld_dmem_we = !imem_sel;
        ld_addr = AW'(adr); ld_data = d;
        @(negedge clk);
        ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
    endtask

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] a, input logic [31:0] b);
        logic en_e; int rg_e; logic [31:0] d_e;
        @(negedge clk);
        rst_n = 1'b0;
        ld_word(1'b0, 0, a);
        ld_word(1'b0, 1, b);
        ld_word(1'b0, 15, 32'hDEADBEEF);
        for (int w = 16; w < 21; w++) ld_word(1'b0, w, 32'h0);
        chk(wb_en == 1'b0, "R1 reset wb_en", {31'd0, wb_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 1; n <= 24; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n < 4) begin
                chk(wb_en == 1'b0, "R1 idle after reset", {31'd0, wb_en}, 32'd0);
            end else begin
                exp_wb(n - 4, a, b, en_e, rg_e, d_e);
                chk(wb_en == en_e, "R2 R6 R7 wb_en", {31'd0, wb_en}, {31'd0, en_e});
                if (en_e) begin
                    chk(wb_reg == 5'(rg_e), "R2 R3 R6 wb_reg", {27'd0, wb_reg}, 32'(rg_e));
                    chk(wb_data == d_e, "R4 R5 R8 R9 wb_data", wb_data, d_e);
                end
            end
        end
        // results stored through r8 = 64 (word 16 onward)
        for (int w = 0; w < 7; w++) begin
            logic [31:0] e;
            case (w)
                0: e = a + b;
                1: e = a - b;
                2: e = a & b;
                3: e = a | b;
                4: e = a - 32'd3;
                5: e = 32'd0;
                default: e = a;
            endcase
            dbg_addr = (w == 5) ? AW'(15) : (w == 6) ? AW'(0) : AW'(16 + w);
            #1;
            chk(dbg_data == e, "R9 R11 R7 R5 stored word", dbg_data, e);
        end
    endtask

    initial begin
        logic [31:0] va [8];
        logic [31:0] vb [8];
        va[0] = 32'h0;        vb[0] = 32'h0;
        va[1] = 32'hFFFFFFFF; vb[1] = 32'h1;
        va[2] = 32'h80000000; vb[2] = 32'h1;
        va[3] = 32'h7FFFFFFF; vb[3] = 32'h7FFFFFFF;
        va[4] = 32'h1;        vb[4] = 32'hFFFFFFFF;
        va[5] = 32'hAAAA5555; vb[5] = 32'h5555AAAA;
        va[6] = 32'h2;        vb[6] = 32'h3;
        va[7] = 32'hF0F0F0F0; vb[7] = 32'h0FF00FF0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 64; k++) ld_word(1'b1, k, prog(k));
        for (int i = 0; i < 8; i++) run_vec(va[i], vb[i]);
        for (int i = 0; i < 16; i++)
            run_vec(32'h9E3779B9 * 32'(i + 1) + 32'h1234, 32'h6A09E667 ^ (32'(i) << (2 * i)));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule